// File: doc/BRIEF.md
# Reduced-Table Iterative CRC Unit

This block updates a running CRC one chunk at a time, where a chunk is `CHUNK_W` bits wide (8 or 16) and no wider than the CRC itself. It does not keep a full 2^`CHUNK_W` entry lookup table. Instead it keeps only `CHUNK_W` constant remainders, one for each single-bit chunk. Entry i is the remainder of x^(`CRC_W`+i) divided by the generator. The table is computed at elaboration from the generator parameter. It is built from x^`CRC_W` mod g(x), and each later entry is the one before multiplied by x modulo g(x).

When a chunk is accepted, the unit forms a word d. This is the chunk XOR the top `CHUNK_W` bits of the current CRC. For the first chunk of a message, the current CRC is taken as zero. The unit then walks d from its least significant bit upward, one bit per cycle. Whenever the examined bit is 1, it XORs the matching table entry into an accumulator. When the walk ends, the new CRC is the accumulator XOR the old CRC's remaining low bits moved up by `CHUNK_W`. If `CHUNK_W` equals `CRC_W`, that moved-up term is zero. The result is the same as a bit-serial CRC with zero initial value, where each chunk is fed MSB first.

A valid/ready handshake delivers chunks. A busy flag covers the fixed iteration window, and a one-cycle done pulse marks each updated result.

Top module: `crc_reduced_table`

## Requirements
- R1: While reset is asserted and right after it, `crcOut` is 0, `busy` is 0, `crcDone` is 0 and `chunkReady` is 1.
- R2: Table entry i (i = 0 to `CHUNK_W`-1) equals x^(`CRC_W`+i) mod g(x). For the 16-bit generator 0x1021 the entries are 1021, 2042, 4084, 8108, 1231, 2462, 48C4, 9188, 3331, 6662, CCC4, 89A9, 0373, 06E6, 0DCC and 1B98 (hex). For the 8-bit generator 0x1D they are 1D, 3A, 74, E8, CD, 87, 13 and 26. With `CHUNK_W` = `CRC_W`, a first chunk with only bit i set yields entry i.
- R3: The working word d is the chunk XOR the CRC's top `CHUNK_W` bits. Bit i of d (bit 0 = LSB) selects entry i, and bits that are 0 contribute nothing.
- R4: The new CRC is the XOR of the selected entries and the old CRC's low `CRC_W`-`CHUNK_W` bits shifted left by `CHUNK_W`. When `CHUNK_W` = `CRC_W`, only the entries contribute.
- R5: A chunk presented with `chunkFirst` = 1 treats the old CRC as zero, which starts a new message.
- R6: A chunk is taken on a clock edge where `chunkValid` and `chunkReady` are both 1. `chunkReady` is the inverse of `busy`. Chunks offered while busy are ignored and do not alter the result.
- R7: After a chunk is taken, `busy` stays high for exactly `CHUNK_W` cycles whatever the data. In the first cycle after that, `busy` is 0, `crcDone` is 1 for that one cycle, and `crcOut` holds the new CRC.
- R8: `crcOut` changes only in a cycle where `crcDone` is 1, and otherwise holds its value.
- R9: Over a message, the result equals a bit-serial CRC with zero initial value, no final inversion, and each chunk fed MSB first. For example, the bytes "123456789" with generator 0x1021 give 0x31C3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chunkValid | input | 1 | A chunk is offered |
| chunkReady | output | 1 | The unit can take a chunk |
| chunkData | input | CHUNK_W | Chunk bits, MSB is the earliest message bit |
| chunkFirst | input | 1 | Chunk starts a new message |
| busy | output | 1 | Iteration in progress |
| crcOut | output | CRC_W | Current CRC value |
| crcDone | output | 1 | One-cycle pulse: crcOut was just updated |

## Verification
A chunk is taken at the first rising edge where valid meets ready. From the falling edge after that edge, `busy` must read 1 on exactly `CHUNK_W` consecutive falling edges. On the next falling edge, `busy` must be 0, `crcDone` must be 1 and `crcOut` must hold the new value. The tasks count those falling edges instead of waiting for the done pulse, so a result that is early or late fails both the cycle-count check and the value check. Hold and ignore checks sample `crcOut` on later falling edges before any new chunk is offered.

// File: rtl/crc_rt_pkg.sv
package crc_rt_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;    // capture a chunk, clear the accumulator
    logic step;    // examine one bit of d
    logic finish;  // last bit: write the new CRC
  } crcStrobe_t;
endpackage

// File: rtl/crc_rt_table.sv
module crc_rt_table #(
  parameter int unsigned CRC_W   = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter int unsigned CHUNK_W = 8,
  localparam int unsigned IDX_W  = $clog2(CHUNK_W)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [CRC_W-1:0] entry
);
  // Remainder of x^(CRC_W+i) mod g: start at x^CRC_W mod g (= POLY), multiply by x i times.
  function automatic logic [CRC_W-1:0] powRem(input int unsigned i);
    logic [CRC_W-1:0] r;
    r = POLY;
    for (int unsigned k = 0; k < i; k++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ POLY) : (r << 1);
    end
    return r;
  endfunction

  logic [CRC_W-1:0] tbl [CHUNK_W];

  for (genvar i = 0; i < CHUNK_W; i++) begin : g_entry
    assign tbl[i] = powRem(i);
  end

  assign entry = tbl[idx];
endmodule

// File: rtl/crc_rt_ctrl.sv
module crc_rt_ctrl
  import crc_rt_pkg::*;
#(
  parameter int unsigned CHUNK_W = 8,
  localparam int unsigned IDX_W  = $clog2(CHUNK_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chunkValid,
  output logic             chunkReady,
  output logic             busy,
  output logic             crcDone,
  output crcStrobe_t       ctl,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHUNK_W - 1);

  logic             busyQ;
  logic             doneQ;
  logic [IDX_W-1:0] cntQ;
  logic             isLast;

  assign isLast     = (cntQ == LAST);
  assign ctl.load   = chunkValid && !busyQ;
  assign ctl.step   = busyQ;
  assign ctl.finish = busyQ && isLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= ctl.finish;
      if (ctl.load) begin
        busyQ <= 1'b1;
        cntQ  <= '0;
      end else if (busyQ) begin
        cntQ <= cntQ + 1'b1;
        if (isLast) busyQ <= 1'b0;
      end
    end
  end

  assign chunkReady = !busyQ;
  assign busy       = busyQ;
  assign crcDone    = doneQ;
  assign idx        = cntQ;

  // Separate run-length counter, used by the window check below.
  logic [IDX_W:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          runLen <= '0;
    else if (ctl.load)  runLen <= '0;
    else if (busyQ)     runLen <= runLen + 1'b1;
  end

  p_run_length_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> (runLen == (IDX_W+1)'(CHUNK_W)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !busyQ);

  p_accept_starts_r6: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && chunkReady) |=> busyQ);
endmodule

// File: rtl/crc_rt_datapath.sv
module crc_rt_datapath
  import crc_rt_pkg::*;
#(
  parameter int unsigned CRC_W   = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter int unsigned CHUNK_W = 8,
  localparam int unsigned IDX_W  = $clog2(CHUNK_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  crcStrobe_t         ctl,
  input  logic [IDX_W-1:0]   idx,
  input  logic [CHUNK_W-1:0] chunkData,
  input  logic               chunkFirst,
  output logic [CRC_W-1:0]   crcOut
);
  logic [CRC_W-1:0]   crcQ;
  logic [CRC_W-1:0]   accQ;
  logic [CHUNK_W-1:0] dQ;
  logic               firstQ;
  logic [CRC_W-1:0]   entry;
  logic [CRC_W-1:0]   accNext;
  logic [CRC_W-1:0]   shiftedOld;
  logic [CHUNK_W-1:0] topBits;

  crc_rt_table #(.CRC_W(CRC_W), .POLY(POLY), .CHUNK_W(CHUNK_W)) u_table (
    .idx   (idx),
    .entry (entry)
  );

  assign topBits = crcQ[CRC_W-1 -: CHUNK_W];

  // Old CRC's leftover low part moved up by one chunk; nothing is left when the chunk fills the CRC.
  if (CHUNK_W == CRC_W) begin : g_full
    assign shiftedOld = '0;
  end else begin : g_part
    assign shiftedOld = {crcQ[CRC_W-CHUNK_W-1:0], {CHUNK_W{1'b0}}};
  end

  assign accNext = dQ[0] ? (accQ ^ entry) : accQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ   <= '0;
      accQ   <= '0;
      dQ     <= '0;
      firstQ <= 1'b0;
    end else begin
      if (ctl.load) begin
        dQ     <= chunkData ^ (chunkFirst ? '0 : topBits);
        accQ   <= '0;
        firstQ <= chunkFirst;
      end else if (ctl.step) begin
        accQ <= accNext;
        dQ   <= dQ >> 1;
        if (ctl.finish) crcQ <= accNext ^ (firstQ ? '0 : shiftedOld);
      end
    end
  end

  assign crcOut = crcQ;

  // On the last step every bit of d other than the one under examination has been consumed.
  p_d_drained_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |-> ((dQ >> 1) == '0));

  p_crc_only_on_finish_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.finish |=> $stable(crcQ));

  p_step_not_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |-> !ctl.load);
endmodule

// File: rtl/crc_reduced_table.sv
module crc_reduced_table
  import crc_rt_pkg::*;
#(
  parameter int unsigned CRC_W   = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chunkValid,
  output logic               chunkReady,
  input  logic [CHUNK_W-1:0] chunkData,
  input  logic               chunkFirst,
  output logic               busy,
  output logic [CRC_W-1:0]   crcOut,
  output logic               crcDone
);
  localparam int unsigned IDX_W = $clog2(CHUNK_W);

  crcStrobe_t       ctl;
  logic [IDX_W-1:0] idx;

  crc_rt_ctrl #(.CHUNK_W(CHUNK_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chunkValid (chunkValid),
    .chunkReady (chunkReady),
    .busy       (busy),
    .crcDone    (crcDone),
    .ctl        (ctl),
    .idx        (idx)
  );

  crc_rt_datapath #(.CRC_W(CRC_W), .POLY(POLY), .CHUNK_W(CHUNK_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .idx        (idx),
    .chunkData  (chunkData),
    .chunkFirst (chunkFirst),
    .crcOut     (crcOut)
  );

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !crcDone |-> $stable(crcOut));
endmodule

// File: tb/crc_reduced_table_tb.sv
module crc_reduced_table_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  int nTests = 0;
  int nFail  = 0;

  // u_dut: CRC-16 0x1021, 8-bit chunks
  logic        aValid = 1'b0, aFirst = 1'b0, aReady, aBusy, aDone;
  logic [7:0]  aData = '0;
  logic [15:0] aCrc;
  // u_dutFull: CRC-16 0x1021, 16-bit chunks
  logic        fValid = 1'b0, fFirst = 1'b0, fReady, fBusy, fDone;
  logic [15:0] fData = '0;
  logic [15:0] fCrc;
  // u_dutByte: CRC-8 0x1D, 8-bit chunks
  logic        bValid = 1'b0, bFirst = 1'b0, bReady, bBusy, bDone;
  logic [7:0]  bData = '0;
  logic [7:0]  bCrc;

  crc_reduced_table #(.CRC_W(16), .POLY(16'h1021), .CHUNK_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .chunkValid(aValid), .chunkReady(aReady), .chunkData(aData),
    .chunkFirst(aFirst), .busy(aBusy), .crcOut(aCrc), .crcDone(aDone));
  crc_reduced_table #(.CRC_W(16), .POLY(16'h1021), .CHUNK_W(16)) u_dutFull (
    .clk(clk), .rstN(rstN), .chunkValid(fValid), .chunkReady(fReady), .chunkData(fData),
    .chunkFirst(fFirst), .busy(fBusy), .crcOut(fCrc), .crcDone(fDone));
  crc_reduced_table #(.CRC_W(8), .POLY(8'h1D), .CHUNK_W(8)) u_dutByte (
    .clk(clk), .rstN(rstN), .chunkValid(bValid), .chunkReady(bReady), .chunkData(bData),
    .chunkFirst(bFirst), .busy(bBusy), .crcOut(bCrc), .crcDone(bDone));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bit-serial reference: zero-based CRC, data MSB first.
  function automatic logic [31:0] refCrc(input logic [31:0] crc, input logic [31:0] data,
                                         input int nbits, input int w, input logic [31:0] poly);
    logic [31:0] mask = (32'd1 << w) - 1;
    for (int b = nbits - 1; b >= 0; b--) begin
      logic fb;
      fb  = crc[w-1] ^ data[b];
      crc = (crc << 1) & mask;
      if (fb) crc = crc ^ poly;
    end
    return crc;
  endfunction

  // Offer one chunk to u_dut, count the busy window, check the result.
  task automatic sendA(input logic [7:0] d, input bit first, input logic [15:0] exp, input string req);
    int runLen = 0;
    @(negedge clk);
    check(aReady === 1'b1, "R6 ready before accept", 32'(aReady), 32'd1);
    aValid = 1'b1; aData = d; aFirst = first;
    @(negedge clk);
    aValid = 1'b0;
    while (aBusy === 1'b1 && runLen < 100) begin
      runLen++;
      @(negedge clk);
    end
    check(runLen == 8, "R7 busy length", 32'(runLen), 32'd8);
    check(aDone === 1'b1, "R7 done pulse", 32'(aDone), 32'd1);
    check(aCrc === exp, req, 32'(aCrc), 32'(exp));
  endtask

  task automatic sendF(input logic [15:0] d, input bit first, input logic [15:0] exp, input string req);
    int runLen = 0;
    @(negedge clk);
    fValid = 1'b1; fData = d; fFirst = first;
    @(negedge clk);
    fValid = 1'b0;
    while (fBusy === 1'b1 && runLen < 100) begin
      runLen++;
      @(negedge clk);
    end
    check(runLen == 16 && fDone === 1'b1, "R7 full-width window", 32'(runLen), 32'd16);
    check(fCrc === exp, req, 32'(fCrc), 32'(exp));
  endtask

  task automatic sendB(input logic [7:0] d, input bit first, input logic [7:0] exp, input string req);
    int runLen = 0;
    @(negedge clk);
    bValid = 1'b1; bData = d; bFirst = first;
    @(negedge clk);
    bValid = 1'b0;
    while (bBusy === 1'b1 && runLen < 100) begin
      runLen++;
      @(negedge clk);
    end
    check(runLen == 8 && bDone === 1'b1, "R7 byte window", 32'(runLen), 32'd8);
    check(bCrc === exp, req, 32'(bCrc), 32'(exp));
  endtask

  task automatic testReset();
    check(aCrc === 16'h0 && fCrc === 16'h0 && bCrc === 8'h0, "R1 crc zero", 32'(aCrc), 32'd0);
    check(aBusy === 1'b0 && aDone === 1'b0, "R1 busy/done low", 32'({aBusy, aDone}), 32'd0);
    check(aReady === 1'b1 && fReady === 1'b1 && bReady === 1'b1, "R1 ready high", 32'(aReady), 32'd1);
  endtask

  task automatic testTables();
    logic [15:0] tFull [16] = '{16'h1021, 16'h2042, 16'h4084, 16'h8108, 16'h1231, 16'h2462,
                                16'h48C4, 16'h9188, 16'h3331, 16'h6662, 16'hCCC4, 16'h89A9,
                                16'h0373, 16'h06E6, 16'h0DCC, 16'h1B98};
    logic [7:0] tByte [8] = '{8'h1D, 8'h3A, 8'h74, 8'hE8, 8'hCD, 8'h87, 8'h13, 8'h26};
    for (int i = 0; i < 16; i++) sendF(16'(1 << i), 1'b1, tFull[i], "R2 full-width entry");
    for (int i = 0; i < 8; i++)  sendB(8'(1 << i), 1'b1, tByte[i], "R2 byte entry");
  endtask

  task automatic testMessage();
    logic [7:0] msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    logic [31:0] r = 0;
    for (int i = 0; i < 9; i++) begin
      r = refCrc((i == 0) ? 32'd0 : r, 32'(msg[i]), 8, 16, 32'h1021);
      sendA(msg[i], i == 0, r[15:0], "R3 R4 chunk update vs bit-serial");
    end
    check(aCrc === 16'h31C3, "R9 check value", 32'(aCrc), 32'h31C3);
  endtask

  task automatic testRestart();
    logic [31:0] r;
    r = refCrc(32'd0, 32'h41, 8, 16, 32'h1021);
    sendA(8'h41, 1'b1, r[15:0], "R5 first chunk reseeds");
    r = refCrc(r, 32'h00, 8, 16, 32'h1021);
    sendA(8'h00, 1'b0, r[15:0], "R4 zero chunk uses shifted old crc");
  endtask

  task automatic testIgnoreAndHold();
    logic [31:0] r;
    int runLen = 0;
    r = refCrc({16'd0, aCrc}, 32'hA5, 8, 16, 32'h1021);
    @(negedge clk);
    aValid = 1'b1; aData = 8'hA5; aFirst = 1'b0;
    @(negedge clk);
    aData = 8'h5A; aFirst = 1'b1;            // junk while busy, R6
    while (aBusy === 1'b1 && runLen < 100) begin
      runLen++;
      if (runLen == 6) aValid = 1'b0;
      @(negedge clk);
    end
    check(runLen == 8, "R6 window unchanged by offers", 32'(runLen), 32'd8);
    check(aCrc === r[15:0], "R6 busy offers ignored", 32'(aCrc), r);
    repeat (4) begin
      @(negedge clk);
      check(aBusy === 1'b0 && aCrc === r[15:0], "R8 crc holds while idle", 32'(aCrc), r);
    end
    check(aDone === 1'b0, "R7 done is a single pulse", 32'(aDone), 32'd0);
  endtask

  task automatic testFullMessage();
    logic [15:0] w [4] = '{16'h3132, 16'h3334, 16'h3536, 16'h3738};
    logic [31:0] r = 0;
    for (int i = 0; i < 4; i++) begin
      r = refCrc((i == 0) ? 32'd0 : r, 32'(w[i]), 16, 16, 32'h1021);
      sendF(w[i], i == 0, r[15:0], "R4 R9 full-width chunk update");
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTables();
    testMessage();
    testRestart();
    testIgnoreAndHold();
    testFullMessage();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule